// File: doc/BRIEF.md
# UDP Port-Steered Receive Ring Address Generator

This block sits behind a UDP receive path and turns each arriving packet descriptor (destination port and payload length) into a placement decision. It compares the destination port with four programmed stream ports and picks a stream. Each stream owns a ring of equally sized receive buffers in host or GPU virtual memory. For each packet the block works out the virtual address where its payload lands and emits a header word. That word carries the address, the payload length, the stream's configured port id and its target-memory flag.

Each stream has its own fill pointer. A buffer is closed with a completion event in three cases: a packet fills it exactly, the next packet would not fit, or a programmable number of idle cycles passes while the buffer is non-empty. The buffer index then advances and wraps after the last buffer of the ring. Packets whose port matches no stream are discarded and counted.

Top module: `udp_ring_addrgen`

## Requirements
- R1: A packet whose destination port equals the programmed port of stream i is steered to stream i. Its header shows stream i (hdr_stream), the stream's port id (hdr_pid) and its target flag (hdr_dev: 0 = host memory, 1 = GPU memory).
- R2: When several streams hold the same port, the lowest-numbered stream wins.
- R3: A packet matching no stream produces no header, and drop_count rises by one (wrapping). Idle cycles change neither.
- R4: The header address is base + buffer_index × buffer_size + fill. Fill then grows by the packet length.
- R5: hdr_valid and its fields appear the cycle after the packet is presented. hdr_len repeats the packet length.
- R6: A packet that brings the fill to exactly the buffer size closes the buffer. evt_valid pulses for one cycle with evt_timeout = 0, evt_bytes = buffer size and evt_index = that buffer's index.
- R7: A packet that would exceed a non-empty buffer first closes it with evt_timeout = 0 and evt_bytes = the old fill. The packet is then placed at offset 0 of the next buffer.
- R8: The buffer index after the last buffer (count − 1) is 0.
- R9: A non-empty buffer that receives no packet closes with evt_timeout = 1 and evt_bytes = its fill. The event appears after the timeout-th clock edge following the edge that accepted its last packet. Each packet restarts the count.
- R10: An empty buffer never produces a timeout event.
- R11: Reset clears hdr_valid, all events, drop_count and every stream's index and fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Packet descriptor present this cycle |
| pkt_dport | input | 16 | UDP destination port of the packet |
| pkt_len | input | LEN_W | Payload length in bytes |
| cfg_dport | input | NS×16 | Destination port per stream |
| cfg_base | input | NS×ADDR_W | Ring base virtual address per stream |
| cfg_bsize | input | NS×BUF_W | Buffer size in bytes per stream |
| cfg_nbuf | input | NS×IDX_W | Number of buffers in each ring |
| cfg_dev | input | NS | Target memory per stream (0 host, 1 GPU) |
| cfg_pid | input | NS×PID_W | Port id written into the header |
| cfg_tmo | input | NS×TMO_W | Idle timeout in cycles per stream |
| hdr_valid | output | 1 | Header word valid |
| hdr_vaddr | output | ADDR_W | Destination virtual address of the payload |
| hdr_stream | output | SEL_W | Selected stream |
| hdr_pid | output | PID_W | Port id of the selected stream |
| hdr_dev | output | 1 | Target memory of the selected stream |
| hdr_len | output | LEN_W | Payload length |
| evt_valid | output | NS | Buffer-closed pulse per stream |
| evt_timeout | output | NS | Cause of closure: 1 timeout, 0 full |
| evt_bytes | output | NS×BUF_W | Bytes held by the closed buffer |
| evt_index | output | NS×IDX_W | Index of the closed buffer |
| drop_count | output | DROP_W | Count of unmatched packets |

## Verification
The properties assume the configuration stays fixed while traffic flows. A port value may change, but base, size, count and timeout may not. Every packet length must be at least one byte and no larger than its buffer. A packet as long as a whole buffer may arrive only while that buffer is empty, and timeouts and buffer counts must be at least one. The stimulus programs the four rings once after reset and changes only a stream port when probing priority. Packet lengths are chosen so that every close, full or spill, happens once per packet, and events from different streams are allowed to overlap in time.

// File: rtl/ring_addr_pkg.sv
package ring_addr_pkg;

    // default geometry of the block
    localparam int STREAMS_DEF = 4;
    localparam int ADDR_W_DEF  = 32;
    localparam int LEN_W_DEF   = 16;
    localparam int BUF_W_DEF   = 20;
    localparam int IDX_W_DEF   = 8;
    localparam int TMO_W_DEF   = 16;
    localparam int PID_W_DEF   = 4;
    localparam int DROP_W_DEF  = 16;
    localparam int PORT_W      = 16;

    // why a buffer was closed
    typedef enum logic {
        CLOSE_FULL    = 1'b0,
        CLOSE_TIMEOUT = 1'b1
    } close_cause_e;

    // selector width that never collapses to zero bits
    function automatic int sel_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/port_steer.sv
module port_steer
    import ring_addr_pkg::*;
#(
    parameter int NS    = STREAMS_DEF,
    parameter int SEL_W = sel_width(NS)
) (
    input  logic                        pkt_valid,
    input  logic [PORT_W-1:0]           pkt_dport,
    input  logic [NS-1:0][PORT_W-1:0]   cfg_dport,
    output logic [NS-1:0]               hit,
    output logic [SEL_W-1:0]            sel,
    output logic                        any_hit
);

    // descending scan: the lowest matching stream is written last and wins
    always_comb begin
        hit     = '0;
        sel     = '0;
        any_hit = 1'b0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (pkt_valid && (pkt_dport == cfg_dport[i])) begin
                hit     = '0;
                hit[i]  = 1'b1;
                sel     = SEL_W'(i);
                any_hit = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ring_slot.sv
module ring_slot
    import ring_addr_pkg::*;
#(
    parameter int LEN_W = LEN_W_DEF,
    parameter int BUF_W = BUF_W_DEF,
    parameter int IDX_W = IDX_W_DEF,
    parameter int TMO_W = TMO_W_DEF,
    parameter int OFF_W = BUF_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [LEN_W-1:0]  len,
    input  logic [BUF_W-1:0]  bsize,
    input  logic [IDX_W-1:0]  nbuf,
    input  logic [TMO_W-1:0]  tmo,
    output logic [OFF_W-1:0]  place_off,
    output logic              evt_valid,
    output close_cause_e      evt_cause,
    output logic [BUF_W-1:0]  evt_bytes,
    output logic [IDX_W-1:0]  evt_index
);

    logic [IDX_W-1:0] idx_q;
    logic [OFF_W-1:0] off_q;
    logic [BUF_W-1:0] fill_q;
    logic [TMO_W-1:0] tmr_q;

    logic             last_cur, last_base;
    logic [IDX_W-1:0] idx_nx1, idx_base, idx_nx2;
    logic [OFF_W-1:0] off_nx1, off_base, off_nx2;
    logic [BUF_W-1:0] fill_base;
    logic [BUF_W:0]   sum_cur, sum_new;
    logic             spill, exact, tmo_hit, busy;

    always_comb begin
        busy      = (fill_q != '0);
        // step from the current buffer
        last_cur  = (idx_q == nbuf - IDX_W'(1));
        idx_nx1   = last_cur ? '0 : idx_q + IDX_W'(1);
        off_nx1   = last_cur ? '0 : off_q + OFF_W'(bsize);
        // would this packet spill out of a non-empty buffer
        sum_cur   = {1'b0, fill_q} + (BUF_W+1)'(len);
        spill     = busy && (sum_cur > {1'b0, bsize});
        // buffer that actually receives the packet
        idx_base  = spill ? idx_nx1 : idx_q;
        off_base  = spill ? off_nx1 : off_q;
        fill_base = spill ? '0 : fill_q;
        sum_new   = {1'b0, fill_base} + (BUF_W+1)'(len);
        exact     = (sum_new == {1'b0, bsize});
        // step from the receiving buffer, used when the packet fills it
        last_base = (idx_base == nbuf - IDX_W'(1));
        idx_nx2   = last_base ? '0 : idx_base + IDX_W'(1);
        off_nx2   = last_base ? '0 : off_base + OFF_W'(bsize);
        place_off = off_base + OFF_W'(fill_base);
        tmo_hit   = busy && (tmr_q == tmo - TMO_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q     <= '0;
            off_q     <= '0;
            fill_q    <= '0;
            tmr_q     <= '0;
            evt_valid <= 1'b0;
            evt_cause <= CLOSE_FULL;
            evt_bytes <= '0;
            evt_index <= '0;
        end else begin
            evt_valid <= 1'b0;
            if (hit) begin
                tmr_q <= '0;
                if (exact) begin
                    fill_q <= '0;
                    idx_q  <= idx_nx2;
                    off_q  <= off_nx2;
                end else begin
                    fill_q <= sum_new[BUF_W-1:0];
                    idx_q  <= idx_base;
                    off_q  <= off_base;
                end
                if (spill) begin
                    evt_valid <= 1'b1;
                    evt_cause <= CLOSE_FULL;
                    evt_bytes <= fill_q;
                    evt_index <= idx_q;
                end else if (exact) begin
                    evt_valid <= 1'b1;
                    evt_cause <= CLOSE_FULL;
                    evt_bytes <= bsize;
                    evt_index <= idx_base;
                end
            end else if (busy) begin
                if (tmo_hit) begin
                    evt_valid <= 1'b1;
                    evt_cause <= CLOSE_TIMEOUT;
                    evt_bytes <= fill_q;
                    evt_index <= idx_q;
                    fill_q    <= '0;
                    idx_q     <= idx_nx1;
                    off_q     <= off_nx1;
                    tmr_q     <= '0;
                end else begin
                    tmr_q <= tmr_q + TMO_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/udp_ring_addrgen.sv
module udp_ring_addrgen
    import ring_addr_pkg::*;
#(
    parameter int NS     = STREAMS_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int LEN_W  = LEN_W_DEF,
    parameter int BUF_W  = BUF_W_DEF,
    parameter int IDX_W  = IDX_W_DEF,
    parameter int TMO_W  = TMO_W_DEF,
    parameter int PID_W  = PID_W_DEF,
    parameter int DROP_W = DROP_W_DEF,
    parameter int SEL_W  = sel_width(NS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       pkt_valid,
    input  logic [PORT_W-1:0]          pkt_dport,
    input  logic [LEN_W-1:0]           pkt_len,
    input  logic [NS-1:0][PORT_W-1:0]  cfg_dport,
    input  logic [NS-1:0][ADDR_W-1:0]  cfg_base,
    input  logic [NS-1:0][BUF_W-1:0]   cfg_bsize,
    input  logic [NS-1:0][IDX_W-1:0]   cfg_nbuf,
    input  logic [NS-1:0]              cfg_dev,
    input  logic [NS-1:0][PID_W-1:0]   cfg_pid,
    input  logic [NS-1:0][TMO_W-1:0]   cfg_tmo,
    output logic                       hdr_valid,
    output logic [ADDR_W-1:0]          hdr_vaddr,
    output logic [SEL_W-1:0]           hdr_stream,
    output logic [PID_W-1:0]           hdr_pid,
    output logic                       hdr_dev,
    output logic [LEN_W-1:0]           hdr_len,
    output logic [NS-1:0]              evt_valid,
    output logic [NS-1:0]              evt_timeout,
    output logic [NS-1:0][BUF_W-1:0]   evt_bytes,
    output logic [NS-1:0][IDX_W-1:0]   evt_index,
    output logic [DROP_W-1:0]          drop_count
);

    localparam int OFF_W = BUF_W + IDX_W;

    logic [NS-1:0]            hit;
    logic [SEL_W-1:0]         sel;
    logic                     any_hit;
    logic [NS-1:0][OFF_W-1:0] place_off;

    port_steer #(.NS(NS), .SEL_W(SEL_W)) u_steer (
        .pkt_valid (pkt_valid),
        .pkt_dport (pkt_dport),
        .cfg_dport (cfg_dport),
        .hit       (hit),
        .sel       (sel),
        .any_hit   (any_hit)
    );

    for (genvar s = 0; s < NS; s++) begin : g_ring
        close_cause_e cause;

        ring_slot #(
            .LEN_W (LEN_W),
            .BUF_W (BUF_W),
            .IDX_W (IDX_W),
            .TMO_W (TMO_W),
            .OFF_W (OFF_W)
        ) u_slot (
            .clk       (clk),
            .rst       (rst),
            .hit       (hit[s]),
            .len       (pkt_len),
            .bsize     (cfg_bsize[s]),
            .nbuf      (cfg_nbuf[s]),
            .tmo       (cfg_tmo[s]),
            .place_off (place_off[s]),
            .evt_valid (evt_valid[s]),
            .evt_cause (cause),
            .evt_bytes (evt_bytes[s]),
            .evt_index (evt_index[s])
        );

        assign evt_timeout[s] = (cause == CLOSE_TIMEOUT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_valid  <= 1'b0;
            hdr_vaddr  <= '0;
            hdr_stream <= '0;
            hdr_pid    <= '0;
            hdr_dev    <= 1'b0;
            hdr_len    <= '0;
            drop_count <= '0;
        end else begin
            hdr_valid <= any_hit;
            if (any_hit) begin
                hdr_vaddr  <= cfg_base[sel] + ADDR_W'(place_off[sel]);
                hdr_stream <= sel;
                hdr_pid    <= cfg_pid[sel];
                hdr_dev    <= cfg_dev[sel];
                hdr_len    <= pkt_len;
            end
            if (pkt_valid && !any_hit) begin
                drop_count <= drop_count + DROP_W'(1);
            end
        end
    end

endmodule

// File: rtl/udp_ring_addrgen_chk.sv
module udp_ring_addrgen_chk #(
    parameter int NS     = 4,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int BUF_W  = 20,
    parameter int IDX_W  = 8,
    parameter int DROP_W = 16,
    parameter int SEL_W  = 2
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      pkt_valid,
    input logic [LEN_W-1:0]          pkt_len,
    input logic [NS-1:0][ADDR_W-1:0] cfg_base,
    input logic [NS-1:0][BUF_W-1:0]  cfg_bsize,
    input logic [NS-1:0][IDX_W-1:0]  cfg_nbuf,
    input logic                      hdr_valid,
    input logic [ADDR_W-1:0]         hdr_vaddr,
    input logic [SEL_W-1:0]          hdr_stream,
    input logic [LEN_W-1:0]          hdr_len,
    input logic [NS-1:0]             evt_valid,
    input logic [NS-1:0]             evt_timeout,
    input logic [NS-1:0][BUF_W-1:0]  evt_bytes,
    input logic [NS-1:0][IDX_W-1:0]  evt_index,
    input logic [DROP_W-1:0]         drop_count
);

    localparam int WW = ADDR_W + BUF_W + IDX_W + 1;

    logic [WW-1:0] ring_end, pkt_end;
    assign ring_end = WW'(cfg_base[hdr_stream])
                    + WW'(cfg_nbuf[hdr_stream]) * WW'(cfg_bsize[hdr_stream]);
    assign pkt_end  = WW'(hdr_vaddr) + WW'(hdr_len);

    // R5
    hdr_follows_pkt_chk: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |-> ($past(pkt_valid) && hdr_len == $past(pkt_len)));

    // R3
    drop_step_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |=> (hdr_valid || drop_count == $past(drop_count) + DROP_W'(1)));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !pkt_valid |=> (!hdr_valid && $stable(drop_count)));

    // R4
    addr_in_ring_chk: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |-> (hdr_vaddr >= cfg_base[hdr_stream] && pkt_end <= ring_end));

    for (genvar s = 0; s < NS; s++) begin : g_evt
        // R6
        evt_bytes_chk: assert property (@(posedge clk) disable iff (rst)
            evt_valid[s] |-> (evt_bytes[s] != '0 && evt_bytes[s] <= cfg_bsize[s]));

        // R8
        evt_index_chk: assert property (@(posedge clk) disable iff (rst)
            evt_valid[s] |-> (evt_index[s] < cfg_nbuf[s]));

        // R9
        tmo_not_on_pkt_chk: assert property (@(posedge clk) disable iff (rst)
            (evt_valid[s] && evt_timeout[s]) |-> !(hdr_valid && hdr_stream == SEL_W'(s)));

        // R6
        evt_pulse_chk: assert property (@(posedge clk) disable iff (rst)
            (evt_valid[s] && !evt_timeout[s]) |=> !(evt_valid[s] && evt_timeout[s]
                && evt_bytes[s] == $past(evt_bytes[s]) && evt_index[s] == $past(evt_index[s])));
    end

endmodule

bind udp_ring_addrgen udp_ring_addrgen_chk #(
    .NS     (NS),
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .BUF_W  (BUF_W),
    .IDX_W  (IDX_W),
    .DROP_W (DROP_W),
    .SEL_W  (SEL_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pkt_valid   (pkt_valid),
    .pkt_len     (pkt_len),
    .cfg_base    (cfg_base),
    .cfg_bsize   (cfg_bsize),
    .cfg_nbuf    (cfg_nbuf),
    .hdr_valid   (hdr_valid),
    .hdr_vaddr   (hdr_vaddr),
    .hdr_stream  (hdr_stream),
    .hdr_len     (hdr_len),
    .evt_valid   (evt_valid),
    .evt_timeout (evt_timeout),
    .evt_bytes   (evt_bytes),
    .evt_index   (evt_index),
    .drop_count  (drop_count)
);

// File: tb/tb_udp_ring_addrgen.sv
module tb_udp_ring_addrgen;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;

    typedef struct packed {
        logic [15:0] dport;
        logic [15:0] len;
        logic        hv;
        logic [1:0]  st;
        logic [31:0] addr;
        logic        ev;
        logic [19:0] evb;
        logic [7:0]  evi;
    } vec_t;

    // s0: 256 B x3 @1000_0000, s1: 100 B x2 @2000_0000, s2: 512 B x4, s3: 64 B x2
    localparam vec_t VEC [13] = '{
        '{16'd1000, 16'd100, 1'b1, 2'd0, 32'h1000_0000, 1'b0, 20'd0,   8'd0}, // R4 first fill
        '{16'd1000, 16'd156, 1'b1, 2'd0, 32'h1000_0064, 1'b1, 20'd256, 8'd0}, // R6 exact fill
        '{16'd1000, 16'd200, 1'b1, 2'd0, 32'h1000_0100, 1'b0, 20'd0,   8'd0}, // R4 buffer 1
        '{16'd1000, 16'd100, 1'b1, 2'd0, 32'h1000_0200, 1'b1, 20'd200, 8'd1}, // R7 spill
        '{16'd1000, 16'd200, 1'b1, 2'd0, 32'h1000_0000, 1'b1, 20'd100, 8'd2}, // R8 wrap
        '{16'd2000, 16'd60,  1'b1, 2'd1, 32'h2000_0000, 1'b0, 20'd0,   8'd0}, // R1
        '{16'd2000, 16'd40,  1'b1, 2'd1, 32'h2000_003C, 1'b1, 20'd100, 8'd0}, // R6
        '{16'd2000, 16'd99,  1'b1, 2'd1, 32'h2000_0064, 1'b0, 20'd0,   8'd0}, // R4
        '{16'd2000, 16'd2,   1'b1, 2'd1, 32'h2000_0000, 1'b1, 20'd99,  8'd1}, // R7 R8
        '{16'd5555, 16'd10,  1'b0, 2'd0, 32'h0,         1'b0, 20'd0,   8'd0}, // R3
        '{16'd3000, 16'd512, 1'b1, 2'd2, 32'h3000_0000, 1'b1, 20'd512, 8'd0}, // R6 whole buffer
        '{16'd4000, 16'd8,   1'b1, 2'd3, 32'h4000_0000, 1'b0, 20'd0,   8'd0}, // R1
        '{16'd0,    16'd1,   1'b0, 2'd0, 32'h0,         1'b0, 20'd0,   8'd0}  // R3
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pkt_valid = 1'b0;
    logic [15:0] pkt_dport = '0;
    logic [15:0] pkt_len = '0;
    logic [NS-1:0][15:0] cfg_dport;
    logic [NS-1:0][31:0] cfg_base;
    logic [NS-1:0][19:0] cfg_bsize;
    logic [NS-1:0][7:0]  cfg_nbuf;
    logic [NS-1:0]       cfg_dev;
    logic [NS-1:0][3:0]  cfg_pid;
    logic [NS-1:0][15:0] cfg_tmo;

    logic                hdr_valid;
    logic [31:0]         hdr_vaddr;
    logic [1:0]          hdr_stream;
    logic [3:0]          hdr_pid;
    logic                hdr_dev;
    logic [15:0]         hdr_len;
    logic [NS-1:0]       evt_valid;
    logic [NS-1:0]       evt_timeout;
    logic [NS-1:0][19:0] evt_bytes;
    logic [NS-1:0][7:0]  evt_index;
    logic [15:0]         drop_count;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    udp_ring_addrgen dut (
        .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_dport(pkt_dport),
        .pkt_len(pkt_len), .cfg_dport(cfg_dport), .cfg_base(cfg_base),
        .cfg_bsize(cfg_bsize), .cfg_nbuf(cfg_nbuf), .cfg_dev(cfg_dev),
        .cfg_pid(cfg_pid), .cfg_tmo(cfg_tmo), .hdr_valid(hdr_valid),
        .hdr_vaddr(hdr_vaddr), .hdr_stream(hdr_stream), .hdr_pid(hdr_pid),
        .hdr_dev(hdr_dev), .hdr_len(hdr_len), .evt_valid(evt_valid),
        .evt_timeout(evt_timeout), .evt_bytes(evt_bytes), .evt_index(evt_index),
        .drop_count(drop_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] dp, input logic [15:0] ln);
        @(negedge clk);
        pkt_valid = 1'b1;
        pkt_dport = dp;
        pkt_len   = ln;
        @(negedge clk);
        pkt_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        if (!done) $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] exp_drop;
        int          first_k [NS];
        int          ev_cnt  [NS];
        logic [19:0] ev_b    [NS];
        logic [7:0]  ev_i    [NS];
        logic        ev_t    [NS];

        cfg_dport = {16'd4000, 16'd3000, 16'd2000, 16'd1000};
        cfg_base  = {32'h4000_0000, 32'h3000_0000, 32'h2000_0000, 32'h1000_0000};
        cfg_bsize = {20'd64, 20'd512, 20'd100, 20'd256};
        cfg_nbuf  = {8'd2, 8'd4, 8'd2, 8'd3};
        cfg_dev   = 4'b0110;
        cfg_pid   = {4'd8, 4'd7, 4'd6, 4'd5};
        cfg_tmo   = {16'd200, 16'd200, 16'd200, 16'd200};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check_eq("R11 hdr_valid", 64'(hdr_valid), 64'd0);
        check_eq("R11 evt_valid", 64'(evt_valid), 64'd0);
        check_eq("R11 drop_count", 64'(drop_count), 64'd0);

        exp_drop = '0;
        for (int v = 0; v < 13; v++) begin
            send(VEC[v].dport, VEC[v].len);
            if (!VEC[v].hv) exp_drop = exp_drop + 16'd1;
            check_eq("R1 R3 hdr_valid", 64'(hdr_valid), 64'(VEC[v].hv));
            if (VEC[v].hv) begin
                check_eq("R4 hdr_vaddr", 64'(hdr_vaddr), 64'(VEC[v].addr));
                check_eq("R1 hdr_stream", 64'(hdr_stream), 64'(VEC[v].st));
                check_eq("R1 hdr_pid", 64'(hdr_pid), 64'(cfg_pid[VEC[v].st]));
                check_eq("R1 hdr_dev", 64'(hdr_dev), 64'(cfg_dev[VEC[v].st]));
                check_eq("R5 hdr_len", 64'(hdr_len), 64'(VEC[v].len));
            end
            check_eq("R6 R7 evt_valid", 64'(evt_valid),
                     VEC[v].ev ? (64'd1 << VEC[v].st) : 64'd0);
            if (VEC[v].ev) begin
                check_eq("R6 R7 evt_bytes", 64'(evt_bytes[VEC[v].st]), 64'(VEC[v].evb));
                check_eq("R8 evt_index", 64'(evt_index[VEC[v].st]), 64'(VEC[v].evi));
                check_eq("R6 evt_timeout", 64'(evt_timeout[VEC[v].st]), 64'd0);
            end
            check_eq("R3 drop_count", 64'(drop_count), 64'(exp_drop));
            @(negedge clk);
            check_eq("R3 idle no header", 64'(hdr_valid), 64'd0);
        end

        // R9 restart: second packet to stream 3 before its first would time out
        send(16'd4000, 16'd4);
        check_eq("R4 s3 second addr", 64'(hdr_vaddr), 64'h4000_0008);
        for (int s = 0; s < NS; s++) begin
            first_k[s] = -1; ev_cnt[s] = 0; ev_b[s] = '0; ev_i[s] = '0; ev_t[s] = 1'b0;
        end
        for (int k = 1; k <= 260; k++) begin
            @(negedge clk);
            for (int s = 0; s < NS; s++) begin
                if (evt_valid[s]) begin
                    ev_cnt[s]++;
                    if (first_k[s] < 0) begin
                        first_k[s] = k;
                        ev_b[s] = evt_bytes[s];
                        ev_i[s] = evt_index[s];
                        ev_t[s] = evt_timeout[s];
                    end
                end
            end
        end
        check_eq("R9 s3 timeout cycle", 64'(first_k[3]), 64'd200);
        check_eq("R9 s3 bytes", 64'(ev_b[3]), 64'd12);
        check_eq("R9 s3 cause", 64'(ev_t[3]), 64'd1);
        check_eq("R9 s3 index", 64'(ev_i[3]), 64'd0);
        check_eq("R9 s0 bytes", 64'(ev_b[0]), 64'd200);
        check_eq("R9 s0 cause", 64'(ev_t[0]), 64'd1);
        check_eq("R9 s1 bytes", 64'(ev_b[1]), 64'd2);
        check_eq("R9 s1 index", 64'(ev_i[1]), 64'd0);
        check_eq("R10 s0 single close", 64'(ev_cnt[0]), 64'd1);
        check_eq("R10 s3 single close", 64'(ev_cnt[3]), 64'd1);
        check_eq("R10 s2 empty never closes", 64'(ev_cnt[2]), 64'd0);

        // R2 duplicate port: stream 0 must win over stream 3
        cfg_dport[3] = 16'd1000;
        send(16'd1000, 16'd8);
        check_eq("R2 priority stream", 64'(hdr_stream), 64'd0);
        check_eq("R2 priority pid", 64'(hdr_pid), 64'd5);
        check_eq("R2 priority addr", 64'(hdr_vaddr), 64'h1000_0100);
        cfg_dport[3] = 16'd4000;

        // R11 mid-run reset returns every ring to its first buffer
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_eq("R11 drop cleared", 64'(drop_count), 64'd0);
        check_eq("R11 header cleared", 64'(hdr_valid), 64'd0);
        send(16'd1000, 16'd16);
        check_eq("R11 s0 restart addr", 64'(hdr_vaddr), 64'h1000_0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule